// File: doc/BRIEF.md
# Control-Register Handshake Sequencer

This block is the bus-side master for a PHY control-register port that uses a four-signal strobe handshake. A single request names a register address and asks for a read, a write, or a read-modify-write of one bit field. The block turns that request into a fixed series of phases on the port. It presents the address and captures it. It then either strobes a read or presents and captures the write data and strobes the write. Each strobe is closed by two waits: one for the acknowledge to rise and one for it to fall.

Every acknowledge wait polls at a fixed spacing and gives up after a bounded number of polls. A timeout at any point abandons every phase still to come. The operation then ends with its error flag set and a zero result. Completion is signalled by a one-cycle pulse in every case. A read-modify-write reads the register and replaces the masked field with a shifted insert value. It then writes the merged word back through a second address phase.

Top module: `ctlreg_seq`

## Requirements
- R1: The address phase drives the request address on `busData` with all strobes low for exactly HOLD_CYC cycles. It then raises `capAddr` with the address still driven and holds it until acknowledge is seen high. It then drops `capAddr` and waits for acknowledge low.
- R2: The read phase first drives `busData` to zero for one cycle with no strobe. It then raises `rdStb` and, when acknowledge is seen high, samples `phyData` into `rdData`. It then drops `rdStb` and waits for acknowledge low.
- R3: A write runs an address phase and then a data-capture phase. The data-capture phase drives the write data for HOLD_CYC cycles and then raises `capData`. The write-strobe phase follows with `wrStb`, and the write data stays unchanged on `busData` from the data-capture phase until the operation ends. At most one of the four strobes is high in any cycle.
- R4: An acknowledge wait polls `ack` in its first cycle and then every POLL_GAP cycles. It makes at most MAX_POLLS polls, so a strobe whose acknowledge never comes stays high for exactly 1+(MAX_POLLS-1)*POLL_GAP cycles. The poll count restarts for every wait, so a wait that succeeds on its last poll does not shorten any later wait.
- R5: When a wait times out, no further strobe is raised for that operation, `err` is 1 and `rdData` is 0. This holds for a timeout in a high wait and in a low wait.
- R6: A read-modify-write reads register A and writes back (old & ~mask) | ((ins << shift) & mask) to A. It returns the old value on `rdData`, and it uses two address phases, one read phase and one data and write-strobe pair.
- R7: `reqReady` is 1 only when idle. A request is accepted only in a cycle where `reqReady` and `reqValid` are both 1. A request presented while busy has no effect.
- R8: `done` is high for exactly one cycle at the end of every operation, whether it succeeded or failed. `err` and `rdData` are valid from that cycle and stay held until the next request is accepted. A plain write returns `rdData` = 0.
- R9: After reset `reqReady`=1, and `done`, `err`, `rdData`, `busData` and all four strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read (ignored when reqRmw=1) |
| reqRmw | input | 1 | 1 = read-modify-write of a field |
| reqAddr | input | ADDR_W | Register address |
| reqWdata | input | DATA_W | Write data for a plain write |
| reqMask | input | DATA_W | Field mask for read-modify-write |
| reqIns | input | DATA_W | Insert value, shifted left before masking |
| reqShift | input | SHIFT_W | Left shift applied to reqIns |
| reqReady | output | 1 | Idle, request can be accepted |
| done | output | 1 | One-cycle end-of-operation pulse |
| err | output | 1 | Last operation timed out |
| rdData | output | DATA_W | Read result, 0 on failure |
| busData | output | BUS_W | Data-out to the control port |
| capAddr | output | 1 | Address-capture strobe |
| capData | output | 1 | Data-capture strobe |
| rdStb | output | 1 | Read strobe |
| wrStb | output | 1 | Write strobe |
| ack | input | 1 | Acknowledge from the control port |
| phyData | input | DATA_W | Read data from the control port |

## Verification
The bench builds the block with POLL_GAP=3, MAX_POLLS=5 and HOLD_CYC=2. With these values a timeout occurs after a 13-cycle strobe, so both sides of the poll limit can be exercised directly. An acknowledge delay of 12 cycles lands on the final poll and must succeed in every phase, which also shows that each wait restarts its count. A delay of 13 cycles must fail. A responder model with adjustable rise and fall delays, a stuck-high acknowledge and a blocked read acknowledge drives the timeout in a high wait, the timeout in a low wait, and the abort of a read-modify-write before its write-back.

// File: rtl/ctlreg_seq_pkg.sv
package ctlreg_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADR_HOLD,
    ST_ADR_HI,
    ST_ADR_LO,
    ST_RD_CLR,
    ST_RD_HI,
    ST_RD_LO,
    ST_MODIFY,
    ST_DAT_HOLD,
    ST_DAT_HI,
    ST_DAT_LO,
    ST_WR_HI,
    ST_WR_LO,
    ST_FIN
  } seqState_e;

  typedef enum logic [1:0] {
    BUS_ZERO,
    BUS_ADDR,
    BUS_WDATA
  } busSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    loadReq;
    busSel_e busSel;
    logic    capAddr;
    logic    capData;
    logic    rdStb;
    logic    wrStb;
    logic    holding;
    logic    waiting;
    logic    waitLevel;
    logic    phaseFirst;
    logic    sampleRd;
    logic    applyMod;
    logic    setErr;
  } seqCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic holdDone;
    logic pollHit;
    logic pollExpire;
  } seqStat_t;

endpackage

// File: rtl/ctlreg_seq_ctrl.sv
module ctlreg_seq_ctrl
  import ctlreg_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     reqWrite,
  input  logic     reqRmw,
  input  seqStat_t stat,
  output seqCtl_t  ctl,
  output logic     ready,
  output logic     done
);

  seqState_e stateQ, stateNxt;
  logic      opWriteQ, opRmwQ, modDoneQ, enterQ;
  logic      acceptReq;
  logic      goWritePath;

  assign acceptReq   = (stateQ == ST_IDLE) && reqValid;
  assign goWritePath = opRmwQ ? modDoneQ : opWriteQ;

  always_comb begin
    stateNxt       = stateQ;
    ctl            = '0;
    ctl.busSel     = BUS_ZERO;
    ctl.phaseFirst = enterQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.loadReq = 1'b1;
          stateNxt    = ST_ADR_HOLD;
        end
      end
      ST_ADR_HOLD: begin
        ctl.busSel  = BUS_ADDR;
        ctl.holding = 1'b1;
        if (stat.holdDone) stateNxt = ST_ADR_HI;
      end
      ST_ADR_HI: begin
        ctl.busSel    = BUS_ADDR;
        ctl.capAddr   = 1'b1;
        ctl.waiting   = 1'b1;
        ctl.waitLevel = 1'b1;
        if (stat.pollHit) stateNxt = ST_ADR_LO;
      end
      ST_ADR_LO: begin
        ctl.busSel  = BUS_ADDR;
        ctl.waiting = 1'b1;
        if (stat.pollHit) stateNxt = goWritePath ? ST_DAT_HOLD : ST_RD_CLR;
      end
      ST_RD_CLR: begin
        stateNxt = ST_RD_HI;
      end
      ST_RD_HI: begin
        ctl.rdStb     = 1'b1;
        ctl.waiting   = 1'b1;
        ctl.waitLevel = 1'b1;
        if (stat.pollHit) begin
          ctl.sampleRd = 1'b1;
          stateNxt     = ST_RD_LO;
        end
      end
      ST_RD_LO: begin
        ctl.waiting = 1'b1;
        if (stat.pollHit) stateNxt = opRmwQ ? ST_MODIFY : ST_FIN;
      end
      ST_MODIFY: begin
        ctl.applyMod = 1'b1;
        stateNxt     = ST_ADR_HOLD;
      end
      ST_DAT_HOLD: begin
        ctl.busSel  = BUS_WDATA;
        ctl.holding = 1'b1;
        if (stat.holdDone) stateNxt = ST_DAT_HI;
      end
      ST_DAT_HI: begin
        ctl.busSel    = BUS_WDATA;
        ctl.capData   = 1'b1;
        ctl.waiting   = 1'b1;
        ctl.waitLevel = 1'b1;
        if (stat.pollHit) stateNxt = ST_DAT_LO;
      end
      ST_DAT_LO: begin
        ctl.busSel  = BUS_WDATA;
        ctl.waiting = 1'b1;
        if (stat.pollHit) stateNxt = ST_WR_HI;
      end
      ST_WR_HI: begin
        ctl.busSel    = BUS_WDATA;
        ctl.wrStb     = 1'b1;
        ctl.waiting   = 1'b1;
        ctl.waitLevel = 1'b1;
        if (stat.pollHit) stateNxt = ST_WR_LO;
      end
      ST_WR_LO: begin
        ctl.busSel  = BUS_WDATA;
        ctl.waiting = 1'b1;
        if (stat.pollHit) stateNxt = ST_FIN;
      end
      ST_FIN: begin
        stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
    // any expired wait abandons the rest of the operation
    if (ctl.waiting && stat.pollExpire) begin
      ctl.setErr = 1'b1;
      stateNxt   = ST_FIN;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      opWriteQ <= 1'b0;
      opRmwQ   <= 1'b0;
      modDoneQ <= 1'b0;
      enterQ   <= 1'b0;
    end else begin
      stateQ <= stateNxt;
      enterQ <= (stateNxt != stateQ);
      if (acceptReq) begin
        opWriteQ <= reqWrite;
        opRmwQ   <= reqRmw;
        modDoneQ <= 1'b0;
      end else if (stateQ == ST_MODIFY) begin
        modDoneQ <= 1'b1;
      end
    end
  end

  assign ready = (stateQ == ST_IDLE);
  assign done  = (stateQ == ST_FIN);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.capAddr, ctl.capData, ctl.rdStb, ctl.wrStb}));

  // R7
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ready && reqValid) |=> !ready);

endmodule

// File: rtl/ctlreg_seq_dp.sv
module ctlreg_seq_dp
  import ctlreg_seq_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int HOLD_CYC  = 2,
  parameter int POLL_GAP  = 5,
  parameter int MAX_POLLS = 1000,
  localparam int BUS_W    = (ADDR_W > DATA_W) ? ADDR_W : DATA_W,
  localparam int SHIFT_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqCtl_t            ctl,
  output seqStat_t           stat,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0]  reqWdata,
  input  logic [DATA_W-1:0]  reqMask,
  input  logic [DATA_W-1:0]  reqIns,
  input  logic [SHIFT_W-1:0] reqShift,
  input  logic               ack,
  input  logic [DATA_W-1:0]  phyData,
  output logic [BUS_W-1:0]   busData,
  output logic [DATA_W-1:0]  rdData,
  output logic               err
);

  localparam int GAP_W  = $clog2(POLL_GAP + 1);
  localparam int POLL_W = $clog2(MAX_POLLS + 1);
  localparam int HOLD_W = $clog2(HOLD_CYC + 1);

  logic [ADDR_W-1:0]  addrQ;
  logic [DATA_W-1:0]  wdQ, maskQ, insQ, rdQ, merged, insShifted;
  logic [SHIFT_W-1:0] shiftQ;
  logic               errQ;

  logic [GAP_W-1:0]  gapQ, gapCur;
  logic [POLL_W-1:0] pollQ, pollCur;
  logic [HOLD_W-1:0] holdQ, holdCur;
  logic              pollNow, ackMatch;

  // ---- poll and hold timing ----
  assign gapCur   = ctl.phaseFirst ? '0 : gapQ;
  assign pollCur  = ctl.phaseFirst ? '0 : pollQ;
  assign holdCur  = ctl.phaseFirst ? '0 : holdQ;
  assign pollNow  = ctl.waiting && (gapCur == '0);
  assign ackMatch = (ack == ctl.waitLevel);

  assign stat.pollHit    = pollNow && ackMatch;
  assign stat.pollExpire = pollNow && !ackMatch && (pollCur == POLL_W'(MAX_POLLS - 1));
  assign stat.holdDone   = ctl.holding && (holdCur == HOLD_W'(HOLD_CYC - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapQ  <= '0;
      pollQ <= '0;
      holdQ <= '0;
    end else begin
      if (ctl.waiting) begin
        if (pollNow) begin
          gapQ  <= GAP_W'(POLL_GAP - 1);
          pollQ <= pollCur + 1'b1;
        end else begin
          gapQ  <= gapCur - 1'b1;
          pollQ <= pollCur;
        end
      end
      if (ctl.holding) holdQ <= holdCur + 1'b1;
    end
  end

  // ---- request holding and field merge ----
  assign insShifted = insQ << shiftQ;
  assign merged     = (rdQ & ~maskQ) | (insShifted & maskQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdQ    <= '0;
      maskQ  <= '0;
      insQ   <= '0;
      shiftQ <= '0;
      rdQ    <= '0;
      errQ   <= 1'b0;
    end else begin
      if (ctl.loadReq) begin
        addrQ  <= reqAddr;
        wdQ    <= reqWdata;
        maskQ  <= reqMask;
        insQ   <= reqIns;
        shiftQ <= reqShift;
        rdQ    <= '0;
        errQ   <= 1'b0;
      end
      if (ctl.sampleRd) rdQ <= phyData;
      if (ctl.applyMod) wdQ <= merged;
      if (ctl.setErr) begin
        rdQ  <= '0;
        errQ <= 1'b1;
      end
    end
  end

  always_comb begin
    unique case (ctl.busSel)
      BUS_ADDR:  busData = BUS_W'(addrQ);
      BUS_WDATA: busData = BUS_W'(wdQ);
      default:   busData = '0;
    endcase
  end

  assign rdData = rdQ;
  assign err    = errQ;

  // R1
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctl.capAddr) |-> $stable(busData));

  // R3
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrStb |-> $stable(busData));

  // R2
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctl.rdStb) |-> ($past(busData) == '0));

  // R4
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    pollQ <= POLL_W'(MAX_POLLS));

endmodule

// File: rtl/ctlreg_seq.sv
module ctlreg_seq
  import ctlreg_seq_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int HOLD_CYC  = 2,
  parameter int POLL_GAP  = 5,
  parameter int MAX_POLLS = 1000,
  localparam int BUS_W    = (ADDR_W > DATA_W) ? ADDR_W : DATA_W,
  localparam int SHIFT_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic               reqRmw,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0]  reqWdata,
  input  logic [DATA_W-1:0]  reqMask,
  input  logic [DATA_W-1:0]  reqIns,
  input  logic [SHIFT_W-1:0] reqShift,
  output logic               reqReady,
  output logic               done,
  output logic               err,
  output logic [DATA_W-1:0]  rdData,
  output logic [BUS_W-1:0]   busData,
  output logic               capAddr,
  output logic               capData,
  output logic               rdStb,
  output logic               wrStb,
  input  logic               ack,
  input  logic [DATA_W-1:0]  phyData
);

  seqCtl_t  ctl;
  seqStat_t stat;

  ctlreg_seq_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqRmw   (reqRmw),
    .stat     (stat),
    .ctl      (ctl),
    .ready    (reqReady),
    .done     (done)
  );

  ctlreg_seq_dp #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .HOLD_CYC  (HOLD_CYC),
    .POLL_GAP  (POLL_GAP),
    .MAX_POLLS (MAX_POLLS)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .stat     (stat),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .reqMask  (reqMask),
    .reqIns   (reqIns),
    .reqShift (reqShift),
    .ack      (ack),
    .phyData  (phyData),
    .busData  (busData),
    .rdData   (rdData),
    .err      (err)
  );

  assign capAddr = ctl.capAddr;
  assign capData = ctl.capData;
  assign rdStb   = ctl.rdStb;
  assign wrStb   = ctl.wrStb;

  // R5
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(err) |-> done);

endmodule

// File: tb/ctlreg_seq_tb_top.sv
`timescale 1ns/1ps
module ctlreg_seq_tb_top;

  localparam int HOLD = 2;
  localparam int GAP  = 3;
  localparam int MAXP = 5;
  localparam int STB_LIMIT = 1 + (MAXP - 1) * GAP;  // 13

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqRmw = 1'b0;
  logic [15:0] reqAddr = '0, reqWdata = '0, reqMask = '0, reqIns = '0;
  logic [3:0]  reqShift = '0;
  logic        reqReady, done, err;
  logic [15:0] rdData, busData;
  logic        capAddr, capData, rdStb, wrStb;
  logic        ack = 1'b0;
  logic [15:0] phyData = '0;

  always #5 clk = ~clk;

  ctlreg_seq #(.ADDR_W(16), .DATA_W(16), .HOLD_CYC(HOLD), .POLL_GAP(GAP), .MAX_POLLS(MAXP)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqRmw(reqRmw),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask), .reqIns(reqIns),
    .reqShift(reqShift), .reqReady(reqReady), .done(done), .err(err), .rdData(rdData),
    .busData(busData), .capAddr(capAddr), .capData(capData), .rdStb(rdStb), .wrStb(wrStb),
    .ack(ack), .phyData(phyData)
  );

  // ---------------- responder model ----------------
  logic [15:0] mem [256];
  logic [15:0] shadow [256];
  logic [15:0] addrL = '0, datL = '0;
  int  hiCnt = 0, loCnt = 0;
  int  ackDly = 2, relDly = 1;
  bit  blockRd = 1'b0;
  wire anyStb = capAddr | capData | rdStb | wrStb;

  always @(posedge clk) begin
    if (capAddr) addrL <= busData;
    if (capData) datL <= busData;
    if (rdStb)   phyData <= mem[addrL[7:0]];
    if (wrStb)   mem[addrL[7:0]] <= datL;
    if (anyStb) begin
      loCnt <= 0;
      if (!ack && !(rdStb && blockRd)) begin
        hiCnt <= hiCnt + 1;
        if (hiCnt + 1 >= ackDly) ack <= 1'b1;
      end
    end else begin
      hiCnt <= 0;
      if (ack) begin
        loCnt <= loCnt + 1;
        if (loCnt + 1 >= relDly) ack <= 1'b0;
      end
    end
  end

  // ---------------- monitor ----------------
  int capAddrRise, capDataRise, rdRise, wrRise, capAddrCyc, rdCyc, doneCnt, preCnt, lastPre;
  logic pCapAddr = 0, pCapData = 0, pRd = 0, pWr = 0;
  logic [15:0] watchAddr = '0;

  always @(negedge clk) begin
    if (capAddr && !pCapAddr) begin capAddrRise++; lastPre = preCnt; end
    if (capData && !pCapData) capDataRise++;
    if (rdStb && !pRd) rdRise++;
    if (wrStb && !pWr) wrRise++;
    if (capAddr) capAddrCyc++;
    if (rdStb) rdCyc++;
    if (done) doneCnt++;
    if (!anyStb && busData == watchAddr) preCnt++; else preCnt = 0;
    pCapAddr = capAddr; pCapData = capData; pRd = rdStb; pWr = wrStb;
  end

  // ---------------- checking ----------------
  int  tests = 0, fails = 0;
  bit  finished = 1'b0;

  task automatic chk(input bit cond, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic runOp(input bit wr, input bit rmw, input logic [15:0] a,
                       input logic [15:0] wd, input logic [15:0] m,
                       input logic [15:0] ins, input logic [3:0] sh,
                       input bit intrude,
                       output bit e, output logic [15:0] rd, output bit ok);
    int n;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqRmw = rmw; reqAddr = a;
    reqWdata = wd; reqMask = m; reqIns = ins; reqShift = sh;
    watchAddr = a;
    @(posedge clk); #1;
    capAddrRise = 0; capDataRise = 0; rdRise = 0; wrRise = 0;
    capAddrCyc = 0; rdCyc = 0; doneCnt = 0; lastPre = -1;
    @(negedge clk);
    reqValid = 1'b0;
    n = 0;
    while (!done && n < 3000) begin
      if (intrude && n < 6) begin
        reqValid = 1'b1; reqWrite = 1'b1; reqRmw = 1'b0;
        reqAddr = 16'h0099; reqWdata = 16'h0000;
        if (n == 2) chk(reqReady == 1'b0, "R7", "ready while busy", reqReady, 0);
      end else begin
        reqValid = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    reqValid = 1'b0;
    e = err; rd = rdData; ok = (n < 3000);
    repeat (3) @(negedge clk);
    #1;
  endtask

  // op table: {wr, rmw, addr, wdata, mask, ins, shift}
  localparam int NV = 8;
  localparam logic [69:0] VECS [NV] = '{
    {1'b1, 1'b0, 16'h0012, 16'hBEEF, 16'h0000, 16'h0000, 4'h0},
    {1'b0, 1'b0, 16'h0012, 16'h0000, 16'h0000, 16'h0000, 4'h0},
    {1'b1, 1'b0, 16'h0034, 16'h1234, 16'h0000, 16'h0000, 4'h0},
    {1'b0, 1'b1, 16'h0034, 16'h0000, 16'h0FF0, 16'h0002, 4'h4},
    {1'b0, 1'b0, 16'h0034, 16'h0000, 16'h0000, 16'h0000, 4'h0},
    {1'b0, 1'b1, 16'h0012, 16'h0000, 16'h7FFF, 16'h7FFF, 4'h0},
    {1'b0, 1'b0, 16'h0012, 16'h0000, 16'h0000, 16'h0000, 4'h0},
    {1'b0, 1'b0, 16'h0077, 16'h0000, 16'h0000, 16'h0000, 4'h0}
  };

  task automatic expectRead(input logic [15:0] a, input string req);
    bit e, ok; logic [15:0] rd;
    runOp(1'b0, 1'b0, a, 16'h0, 16'h0, 16'h0, 4'h0, 1'b0, e, rd, ok);
    chk(ok && !e && rd == shadow[a[7:0]], req, "read-back value", rd, shadow[a[7:0]]);
  endtask

  initial begin
    bit e, ok;
    logic [15:0] rd, expRd;
    for (int i = 0; i < 256; i++) begin
      mem[i]    = {8'(i) ^ 8'h5A, 8'(i)};
      shadow[i] = {8'(i) ^ 8'h5A, 8'(i)};
    end

    // R9 reset state
    repeat (3) @(negedge clk);
    chk(reqReady && !done && !err && rdData == 0 && busData == 0 && !anyStb,
        "R9", "outputs in reset", {reqReady, done, err, anyStb}, 4'b1000);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady && !done && !err && rdData == 0 && busData == 0 && !anyStb,
        "R9", "outputs after reset", {reqReady, done, err, anyStb}, 4'b1000);

    // table walked twice with two acknowledge timings
    for (int pass = 0; pass < 2; pass++) begin
      ackDly = (pass == 0) ? 2 : 5;
      relDly = (pass == 0) ? 1 : 4;
      for (int v = 0; v < NV; v++) begin
        logic vw, vr; logic [15:0] va, vd, vm, vi; logic [3:0] vs;
        {vw, vr, va, vd, vm, vi, vs} = VECS[v];
        runOp(vw, vr, va, vd, vm, vi, vs, 1'b0, e, rd, ok);
        if (vr) begin
          expRd = shadow[va[7:0]];
          shadow[va[7:0]] = (expRd & ~vm) | ((vi << vs) & vm);
        end else if (vw) begin
          expRd = 16'h0;
          shadow[va[7:0]] = vd;
        end else begin
          expRd = shadow[va[7:0]];
        end
        chk(ok && !e, "R8", "op finished without error", e, 0);
        chk(doneCnt == 1, "R8", "single done pulse", doneCnt, 1);
        if (vr) begin
          chk(rd == expRd, "R6", "rmw returns old value", rd, expRd);
          chk(capAddrRise == 2 && rdRise == 1 && capDataRise == 1 && wrRise == 1,
              "R6", "rmw phase counts", {capAddrRise, rdRise, capDataRise, wrRise}, 32'h2111);
          chk(mem[va[7:0]] == shadow[va[7:0]], "R6", "merged word stored",
              mem[va[7:0]], shadow[va[7:0]]);
        end else if (vw) begin
          chk(rd == 16'h0, "R8", "write returns zero", rd, 0);
          chk(capAddrRise == 1 && rdRise == 0 && capDataRise == 1 && wrRise == 1,
              "R3", "write phase counts", {capAddrRise, rdRise, capDataRise, wrRise}, 32'h1011);
          chk(mem[va[7:0]] == vd, "R3", "write data stored", mem[va[7:0]], vd);
        end else begin
          chk(rd == expRd, "R2", "read data", rd, expRd);
          chk(capAddrRise == 1 && rdRise == 1 && capDataRise == 0 && wrRise == 0,
              "R2", "read phase counts", {capAddrRise, rdRise, capDataRise, wrRise}, 32'h1100);
        end
      end
    end
    ackDly = 2; relDly = 1;

    // R1 address held exactly HOLD cycles before capture
    runOp(1'b0, 1'b0, 16'h0055, 16'h0, 16'h0, 16'h0, 4'h0, 1'b0, e, rd, ok);
    chk(lastPre == HOLD, "R1", "address cycles before capAddr", lastPre, HOLD);
    chk(rd == shadow[8'h55], "R2", "read of preset register", rd, shadow[8'h55]);

    // R4 acknowledge on the final poll of every wait succeeds
    ackDly = STB_LIMIT - 1; relDly = STB_LIMIT - 1;
    runOp(1'b0, 1'b1, 16'h0034, 16'h0, 16'h000F, 16'h0005, 4'h0, 1'b0, e, rd, ok);
    expRd = shadow[8'h34];
    shadow[8'h34] = (expRd & 16'hFFF0) | 16'h0005;
    chk(ok && !e, "R4", "last-poll ack succeeds in every wait", e, 0);
    chk(capAddrCyc == 2 * STB_LIMIT, "R4", "capAddr high cycles", capAddrCyc, 2 * STB_LIMIT);
    chk(rd == expRd, "R4", "rmw old value at slow ack", rd, expRd);
    ackDly = 2; relDly = 1;
    expectRead(16'h0034, "R4");

    // R4 / R5 acknowledge one cycle too late: timeout in high wait
    ackDly = STB_LIMIT;
    runOp(1'b0, 1'b0, 16'h0012, 16'h0, 16'h0, 16'h0, 4'h0, 1'b0, e, rd, ok);
    chk(capAddrCyc == STB_LIMIT, "R4", "strobe length on timeout", capAddrCyc, STB_LIMIT);
    chk(e == 1'b1 && rd == 16'h0, "R5", "timeout err and zero data", {e, rd}, 17'h10000);
    chk(rdRise == 0 && doneCnt == 1, "R5", "no read strobe after abort", rdRise, 0);
    ackDly = 2;
    repeat (20) @(negedge clk);

    // R8 err cleared by next good op
    runOp(1'b0, 1'b0, 16'h0012, 16'h0, 16'h0, 16'h0, 4'h0, 1'b0, e, rd, ok);
    chk(!e && rd == shadow[8'h12], "R8", "err cleared on next op", {e, rd}, {1'b0, shadow[8'h12]});

    // R5 stuck-high ack: timeout in low wait of address phase
    relDly = 100000;
    runOp(1'b1, 1'b0, 16'h0040, 16'hAAAA, 16'h0, 16'h0, 4'h0, 1'b0, e, rd, ok);
    chk(e == 1'b1, "R5", "low-wait timeout err", e, 1);
    chk(capDataRise == 0 && wrRise == 0, "R5", "no data/write strobe", capDataRise + wrRise, 0);
    relDly = 1;
    repeat (10) @(negedge clk);
    expectRead(16'h0040, "R5");

    // R5 failed read returns zero and rmw skips write-back
    blockRd = 1'b1;
    runOp(1'b0, 1'b1, 16'h0012, 16'h0, 16'hFFFF, 16'h1111, 4'h0, 1'b0, e, rd, ok);
    chk(e == 1'b1 && rd == 16'h0, "R5", "failed read returns zero", {e, rd}, 17'h10000);
    chk(rdCyc == STB_LIMIT && capDataRise == 0 && wrRise == 0,
        "R5", "rmw aborted before write-back", rdCyc, STB_LIMIT);
    blockRd = 1'b0;
    repeat (10) @(negedge clk);
    expectRead(16'h0012, "R5");

    // R7 request while busy has no effect
    runOp(1'b1, 1'b0, 16'h0020, 16'h5A5A, 16'h0, 16'h0, 4'h0, 1'b1, e, rd, ok);
    shadow[8'h20] = 16'h5A5A;
    chk(doneCnt == 1 && !e, "R7", "one op for intruded request", doneCnt, 1);
    expectRead(16'h0099, "R7");
    expectRead(16'h0020, "R3");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule